// File: doc/BRIEF.md
# Condition Code and Branch Unit

This block adds or subtracts two operands and derives four condition flags from the result: negative, zero, signed overflow and carry/borrow. The flags are stored in a condition-code register. The register loads only when the update enable is asserted, so later instructions can leave it untouched. A 4-bit condition selector picks one of sixteen branch tests, and each test is applied to the stored flags.

Subtraction is done as A + ~B + 1. The carry flag is then inverted, so after a subtraction it reads as a borrow. The signed tests combine the negative and overflow flags through an exclusive OR. The branch decision is combinational and uses only the registered flags, never the flags of the operation currently on the inputs. A parameter sets the data width. A second parameter chooses between the borrow convention and reporting the raw carry-out on subtraction.

Top module: `ccbu_top`

## Requirements
- R1: When `sub_sel`=0, `result` = (`a_in` + `b_in`) mod 2^WIDTH. The next stored C is the carry-out of the top bit.
- R2: When `sub_sel`=1, `result` = (`a_in` − `b_in`) mod 2^WIDTH. The next stored C is 1 exactly when `a_in` < `b_in` unsigned, which is a borrow.
- R3: The next stored V is 1 when the signed result of the operation falls outside the signed WIDTH-bit range.
- R4: The next stored N equals the top bit of `result`. The next stored Z is 1 only when every bit of `result` is 0.
- R5: The flags load on a rising edge only while `flag_we`=1. While `flag_we`=0 they keep their previous value.
- R6: While `rst`=1, a rising edge clears the stored flags to 0000. Reset takes priority over `flag_we`.
- R7: `flags` carries the stored flags with N in bit 3, Z in bit 2, V in bit 1 and C in bit 0.
- R8: Single-flag tests: code 2 is Z=1, 3 is Z=0, 4 is N=1, 5 is N=0, 6 is V=1, 7 is V=0.
- R9: Signed tests: code 10 (lt) is N^V, 11 (ge) is !(N^V), 12 (le) is Z|(N^V), 13 (gt) is !(Z|(N^V)).
- R10: Unsigned tests: code 8 (lower) is C=1, 9 (higher-or-same) is C=0, 14 (lower-or-same) is Z|C, 15 (higher) is !(Z|C).
- R11: Code 0 gives `branch_taken`=0 for any flags. Code 1 gives `branch_taken`=1 for any flags.
- R12: `branch_taken` depends only on the stored flags and `cond_sel`. Operand changes made while `flag_we`=0 have no effect on it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| a_in | input | WIDTH | First operand |
| b_in | input | WIDTH | Second operand |
| sub_sel | input | 1 | 0 = add, 1 = subtract |
| flag_we | input | 1 | Loads the computed flags into the register |
| cond_sel | input | 4 | Branch condition code |
| result | output | WIDTH | Combinational sum or difference |
| flags | output | 4 | Stored flags {N,Z,V,C} |
| branch_taken | output | 1 | Selected condition evaluated on the stored flags |

## Verification
The bench builds the unit with WIDTH=8 and the borrow convention on. This puts the byte-wide worked cases within reach: carry out of 1F+FF, overflow of A0+A0, borrow of 40−C0, and the zero results of 01+FF and 40−40. It also covers the operand edge values 00 and 80, whose complement handling is the usual source of overflow bugs. Every condition code is then swept across flag states left by comparisons that come out equal, greater, signed-less and overflowing.

// File: rtl/ccbu_pkg.sv
package ccbu_pkg;

   typedef struct packed {
      logic n;
      logic z;
      logic v;
      logic c;
   } ccbu_flags_t;

   typedef enum logic [3:0] {
      COND_NEVER  = 4'h0,
      COND_ALWAYS = 4'h1,
      COND_ZSET   = 4'h2,
      COND_ZCLR   = 4'h3,
      COND_NSET   = 4'h4,
      COND_NCLR   = 4'h5,
      COND_VSET   = 4'h6,
      COND_VCLR   = 4'h7,
      COND_LOWER  = 4'h8,
      COND_HS     = 4'h9,
      COND_SLT    = 4'hA,
      COND_SGE    = 4'hB,
      COND_SLE    = 4'hC,
      COND_SGT    = 4'hD,
      COND_LS     = 4'hE,
      COND_HIGHER = 4'hF
   } ccbu_cond_e;

endpackage

// File: rtl/ccbu_alu.sv
module ccbu_alu
   import ccbu_pkg::*;
#(
   parameter int WIDTH      = 8,
   parameter bit SUB_BORROW = 1'b1
) (
   input  logic [WIDTH-1:0] a_in,
   input  logic [WIDTH-1:0] b_in,
   input  logic             sub_sel,
   output logic [WIDTH-1:0] result,
   output ccbu_flags_t      flags_d
);
   localparam int MSB = WIDTH - 1;

   logic [WIDTH-1:0] b_eff;
   logic [WIDTH:0]   sum_ext;
   logic             carry_out;
   logic             c_flag;

   always_comb begin
      b_eff     = sub_sel ? ~b_in : b_in;
      sum_ext   = {1'b0, a_in} + {1'b0, b_eff} + {{WIDTH{1'b0}}, sub_sel};
      carry_out = sum_ext[WIDTH];
      result    = sum_ext[MSB:0];
   end

   generate
      if (SUB_BORROW) begin : g_borrow
         assign c_flag = sub_sel ? ~carry_out : carry_out;
      end else begin : g_rawcarry
         assign c_flag = carry_out;
      end
   endgenerate

   always_comb begin
      flags_d.n = result[MSB];
      flags_d.z = (result == '0);
      flags_d.v = (a_in[MSB] == b_eff[MSB]) && (result[MSB] != a_in[MSB]);
      flags_d.c = c_flag;
   end

endmodule

// File: rtl/ccbu_flagreg.sv
module ccbu_flagreg
   import ccbu_pkg::*;
(
   input  logic        clk,
   input  logic        rst,
   input  logic        we,
   input  ccbu_flags_t d,
   output ccbu_flags_t q
);

   always_ff @(posedge clk) begin
      if (rst)
         q <= '0;
      else if (we)
         q <= d;
   end

   AST_RESET_CLEARS: assert property (@(posedge clk) rst |=> (q == '0)); // R6
   AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst) !we |=> $stable(q)); // R5
   AST_LOAD_ENABLED: assert property (@(posedge clk) disable iff (rst) we |=> (q == $past(d))); // R5

endmodule

// File: rtl/ccbu_cond.sv
module ccbu_cond
   import ccbu_pkg::*;
(
   input  ccbu_flags_t fl,
   input  logic [3:0]  cond_sel,
   output logic        taken
);
   logic sgn_lt;
   logic uns_ls;

   always_comb begin
      sgn_lt = fl.n ^ fl.v;
      uns_ls = fl.z | fl.c;
      unique case (ccbu_cond_e'(cond_sel))
         COND_NEVER:  taken = 1'b0;
         COND_ALWAYS: taken = 1'b1;
         COND_ZSET:   taken = fl.z;
         COND_ZCLR:   taken = ~fl.z;
         COND_NSET:   taken = fl.n;
         COND_NCLR:   taken = ~fl.n;
         COND_VSET:   taken = fl.v;
         COND_VCLR:   taken = ~fl.v;
         COND_LOWER:  taken = fl.c;
         COND_HS:     taken = ~fl.c;
         COND_SLT:    taken = sgn_lt;
         COND_SGE:    taken = ~sgn_lt;
         COND_SLE:    taken = fl.z | sgn_lt;
         COND_SGT:    taken = ~(fl.z | sgn_lt);
         COND_LS:     taken = uns_ls;
         COND_HIGHER: taken = ~uns_ls;
         default:     taken = 1'b0;
      endcase
   end

endmodule

// File: rtl/ccbu_top.sv
module ccbu_top
   import ccbu_pkg::*;
#(
   parameter int WIDTH      = 8,
   parameter bit SUB_BORROW = 1'b1
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [WIDTH-1:0] a_in,
   input  logic [WIDTH-1:0] b_in,
   input  logic             sub_sel,
   input  logic             flag_we,
   input  logic [3:0]       cond_sel,
   output logic [WIDTH-1:0] result,
   output logic [3:0]       flags,
   output logic             branch_taken
);
   localparam int MSB = WIDTH - 1;

   generate
      if (WIDTH < 2) begin : g_bad_width
         $error("ccbu_top: WIDTH must be at least 2");
      end
   endgenerate

   ccbu_flags_t flags_d;
   ccbu_flags_t flags_q;

   ccbu_alu #(.WIDTH(WIDTH), .SUB_BORROW(SUB_BORROW)) u_alu (
      .a_in    (a_in),
      .b_in    (b_in),
      .sub_sel (sub_sel),
      .result  (result),
      .flags_d (flags_d)
   );

   ccbu_flagreg u_reg (
      .clk (clk),
      .rst (rst),
      .we  (flag_we),
      .d   (flags_d),
      .q   (flags_q)
   );

   ccbu_cond u_cond (
      .fl       (flags_q),
      .cond_sel (cond_sel),
      .taken    (branch_taken)
   );

   assign flags = {flags_q.n, flags_q.z, flags_q.v, flags_q.c};

   AST_ADD_CARRY: assert property (@(posedge clk) disable iff (rst)
      !sub_sel |-> (flags_d.c == (result < a_in))); // R1
   generate
      if (SUB_BORROW) begin : g_borrow_chk
         AST_SUB_BORROW: assert property (@(posedge clk) disable iff (rst)
            sub_sel |-> (flags_d.c == (a_in < b_in))); // R2
      end
   endgenerate
   AST_ZERO_RESULT: assert property (@(posedge clk) disable iff (rst)
      flags_d.z |-> (result == '0)); // R4
   AST_SIGN_BIT: assert property (@(posedge clk) disable iff (rst)
      flag_we |=> (flags[3] == $past(result[MSB]))); // R4
   AST_NEVER_TAKEN: assert property (@(posedge clk) disable iff (rst)
      (cond_sel == 4'h0) |-> !branch_taken); // R11
   AST_ALWAYS_TAKEN: assert property (@(posedge clk) disable iff (rst)
      (cond_sel == 4'h1) |-> branch_taken); // R11
   AST_TAKEN_FROM_REG: assert property (@(posedge clk) disable iff (rst)
      !flag_we |=> ($stable(cond_sel) -> $stable(branch_taken))); // R12

endmodule

// File: tb/tb_ccbu_top.sv
`timescale 1ns/1ps
module tb_ccbu_top;
   localparam int W = 8;

   logic         clk = 1'b0;
   logic         rst = 1'b1;
   logic [W-1:0] a_in = '0;
   logic [W-1:0] b_in = '0;
   logic         sub_sel = 1'b0;
   logic         flag_we = 1'b0;
   logic [3:0]   cond_sel = 4'h0;
   logic [W-1:0] result;
   logic [3:0]   flags;
   logic         branch_taken;

   always #2 clk = ~clk;

   ccbu_top #(.WIDTH(W), .SUB_BORROW(1'b1)) dut (
      .clk(clk), .rst(rst), .a_in(a_in), .b_in(b_in), .sub_sel(sub_sel),
      .flag_we(flag_we), .cond_sel(cond_sel), .result(result),
      .flags(flags), .branch_taken(branch_taken)
   );

   typedef struct {
      logic [W-1:0] res;
      logic [3:0]   fl;
      logic         tk;
      string        tag;
   } exp_t;

   exp_t       sb[$];
   logic [3:0] mflags = 4'h0;
   int         total = 0;
   int         fails = 0;
   bit         done  = 0;

   // Model flag order {N,Z,V,C} (R7)
   function automatic logic cond_fn(input logic [3:0] f, input int cd);
      logic n, z, v, c;
      n = f[3]; z = f[2]; v = f[1]; c = f[0];
      case (cd)
         0:  return 1'b0;
         1:  return 1'b1;
         2:  return z;
         3:  return !z;
         4:  return n;
         5:  return !n;
         6:  return v;
         7:  return !v;
         8:  return c;
         9:  return !c;
         10: return n != v;
         11: return n == v;
         12: return z || (n != v);
         13: return !z && (n == v);
         14: return c || z;
         default: return !c && !z;
      endcase
   endfunction

   function automatic string cond_tag(input int cd);
      if (cd < 2) return "R11";
      if (cd < 8) return "R8";
      if (cd >= 10 && cd <= 13) return "R9";
      return "R10";
   endfunction

   task automatic drive(input logic r, input logic [W-1:0] a, input logic [W-1:0] b,
                        input logic s, input logic w, input int cd, input string tag);
      int ia, ib, full, sa, sb_i, sv;
      logic [W-1:0] res;
      logic [3:0] nf;
      exp_t e;
      @(negedge clk);
      rst = r; a_in = a; b_in = b; sub_sel = s; flag_we = w; cond_sel = cd[3:0];
      ia = int'(a); ib = int'(b);
      sa = (ia > 127) ? ia - 256 : ia;
      sb_i = (ib > 127) ? ib - 256 : ib;
      if (!s) begin
         full = ia + ib;  sv = sa + sb_i;
         nf[0] = (full > 255);
      end else begin
         full = ia - ib;  sv = sa - sb_i;
         nf[0] = (ia < ib);
      end
      res   = full[W-1:0];
      nf[3] = res[W-1];
      nf[2] = (res == 0);
      nf[1] = (sv > 127) || (sv < -128);
      if (r) mflags = 4'h0;
      else if (w) mflags = nf;
      e.res = res; e.fl = mflags; e.tk = cond_fn(mflags, cd); e.tag = tag;
      sb.push_back(e);
   endtask

   task automatic chk(input bit ok, input string what, input string tag, input int act, input int exp);
      total++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
      end
   endtask

   // Monitor: pops one expected item per edge, sampled after the edge
   initial begin
      forever begin
         @(posedge clk);
         #1;
         if (sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            chk(result === e.res, "result", e.tag, int'(result), int'(e.res));
            chk(flags === e.fl, "flags{N,Z,V,C} R7", e.tag, int'(flags), int'(e.fl));
            chk(branch_taken === e.tk, "branch_taken", e.tag, int'(branch_taken), int'(e.tk));
         end
      end
   end

   initial begin
      #40000;
      if (!done) begin
         done = 1;
         total++; fails++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("%0d/%0d checks passed", total - fails, total);
         $finish;
      end
   end

   initial begin
      // R6: reset wins over the update enable
      drive(1, 8'h01, 8'hFF, 0, 1, 2, "R6");
      drive(1, 8'h40, 8'h40, 0, 1, 3, "R6");
      // R1/R3/R4: additions
      drive(0, 8'h1F, 8'hFF, 0, 1, 8, "R1");
      drive(0, 8'h01, 8'hFF, 0, 1, 2, "R4");
      drive(0, 8'h40, 8'h40, 0, 1, 6, "R3");
      drive(0, 8'hA0, 8'hA0, 0, 1, 6, "R3");
      drive(0, 8'h00, 8'h01, 0, 1, 2, "R1");
      drive(0, 8'hFF, 8'h01, 0, 1, 3, "R4");
      // R2/R3: subtractions with borrow
      drive(0, 8'h1F, 8'hFF, 1, 1, 8, "R2");
      drive(0, 8'h01, 8'hFF, 1, 1, 9, "R2");
      drive(0, 8'hFF, 8'h01, 1, 1, 4, "R2");
      drive(0, 8'h22, 8'h00, 1, 1, 5, "R2");
      drive(0, 8'h40, 8'h40, 1, 1, 2, "R4");
      drive(0, 8'hA0, 8'h60, 1, 1, 6, "R3");
      drive(0, 8'h40, 8'hC0, 1, 1, 6, "R3");
      drive(0, 8'h00, 8'h80, 1, 1, 6, "R3");
      drive(0, 8'h80, 8'h00, 1, 1, 7, "R3");
      // R5/R12: operands change with enable low, flags and decision hold
      drive(0, 8'h7F, 8'h01, 0, 0, 6, "R12");
      drive(0, 8'h00, 8'h00, 1, 0, 2, "R5");
      drive(0, 8'h05, 8'h05, 1, 0, 12, "R12");
      // R6: mid-stream reset
      drive(0, 8'hFF, 8'hFF, 0, 1, 4, "R6");
      drive(1, 8'hFF, 8'hFF, 0, 1, 4, "R6");
      // R8-R11: full condition sweep across comparison outcomes
      begin
         logic [W-1:0] pa [5] = '{8'h05, 8'h03, 8'h05, 8'h80, 8'h01};
         logic [W-1:0] pb [5] = '{8'h03, 8'h05, 8'h05, 8'h01, 8'h80};
         for (int p = 0; p < 5; p++) begin
            drive(0, pa[p], pb[p], 1, 1, 1, "R2");
            for (int cd = 0; cd < 16; cd++)
               drive(0, 8'h3C ^ 8'(cd), 8'(cd), cd[0], 0, cd, cond_tag(cd));
         end
      end
      repeat (3) @(negedge clk);
      if (!done) begin
         done = 1;
         $display("%0d/%0d checks passed", total - fails, total);
         $finish;
      end
   end

endmodule